// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a single-port synchronous static memory of 36-bit words, each word split into four 9-bit bytes, with a built-in 2-bit burst address sequencer. Every control and data input is captured on the rising clock edge. An access starts on either of two start strobes and continues, one word per clock, while an advance input is held. The low two address bits step in linear or interleaved order, chosen by a static order input. Each start strobe has its own rules for writes and chip select.

Read data leaves the block either straight from the array in the cycle after the command is captured, or one clock later through an output register. A static latency input selects between the two. Deselect takes one register stage fewer than read data, so a deselect shuts the output at once. Output enable and sleep act without the clock. Sleep also freezes the memory against new accesses and keeps its contents.

Top module: `sburst_sram`

## Requirements
- R1: The block is selected only when `cs1_n` is 0, `cs2` is 1 and `cs3_n` is 0. A start strobe sampled with any other combination is a deselect, and `rvalid` is 0 after that edge.
- R2: With `pipe_sel` = 0, a read captured at clock edge k drives `rvalid` = 1 and the addressed word on `rdata` from just after edge k.
- R3: With `pipe_sel` = 1, a read captured at edge k drives its word from just after edge k+1. Reads may be started on consecutive edges, with one word out per clock.
- R4: A start latches the base address with step count 0. Each later edge with `adv` = 1 increments the 2-bit count, which wraps after four steps. An edge with `adv` = 0 repeats the current address. The low two address bits are base+count mod 4 when `order_lin` = 1, and base XOR count when `order_lin` = 0. The upper bits stay at the base value.
- R5: A `start_b` access is a write when `gwr` = 1, or when `bwen` = 1 and at least one `bsel` bit is 1. Otherwise it is a read, and memory is unchanged. A write leaves `rvalid` at 0 after its edge in flow-through mode.
- R6: In a byte write, only byte i (bits 9i+8 down to 9i) with `bsel[i]` = 1 takes the new data. The other bytes keep their old value.
- R7: `gwr` = 1 writes all four bytes, whatever `bwen` and `bsel` are.
- R8: `start_a` always starts a read and ignores the write controls. `start_a` has no effect at all when `cs1_n` = 1. `start_a` takes priority over `start_b`.
- R9: A deselect captured at edge k sets `rvalid` to 0 right after edge k in both modes. In pipeline mode this also suppresses the word of a read captured at edge k-1. After a deselect, `adv` alone starts nothing.
- R10: While `oe_n` = 1, `rvalid` = 0 and `rdata` = 0, with no clock edge needed. Lowering `oe_n` restores the output.
- R11: While `sleep` = 1, `rvalid` = 0 and `rdata` = 0 at once. Edges taken in sleep perform no access and keep memory contents. The first edge after `sleep` falls accepts a command.
- R12: After reset, `rvalid` = 0 and no burst is active, so `adv` with no start strobe gives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address sampled with a start strobe |
| wdata | input | 36 | Write data, four 9-bit bytes |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| start_a | input | 1 | Read-only start strobe, gated by cs1_n |
| start_b | input | 1 | Read or write start strobe |
| adv | input | 1 | Burst advance |
| gwr | input | 1 | Global write, all bytes |
| bwen | input | 1 | Byte write enable |
| bsel | input | 4 | Per-byte write selects |
| pipe_sel | input | 1 | Static latency select: 1 registered, 0 flow-through |
| order_lin | input | 1 | Static burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power hold |
| rdata | output | 36 | Read data, zero when not driven |
| rvalid | output | 1 | Output driven (models the pad enable) |

## Verification
Two cases can land on the same edge. In pipeline mode, a deselect can be captured on the very edge at which the previous read's word would come out of the output register. The bench provokes this with a read and a deselect on back-to-back edges. It judges the result by `rvalid` being 0 right after the deselect edge instead of carrying the earlier word. Sleep can also coincide with a fully valid write command. That write is issued with sleep high, and the bench then reads the address after wake-up and requires the old shadow-memory word.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int BYTES  = 4;
    localparam int BYTE_W = 9;
    localparam int WORD_W = BYTES * BYTE_W;

    typedef enum logic [2:0] {
        K_NONE,
        K_LOAD,
        K_STEP,
        K_HOLD,
        K_DESEL
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic             wr;
        logic [BYTES-1:0] mask;
    } cmd_t;

    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] cnt,
                                            input logic       linear);
        return linear ? (base + cnt) : (base ^ cnt);
    endfunction

    function automatic logic is_access(input kind_e k);
        return (k == K_LOAD) || (k == K_STEP) || (k == K_HOLD);
    endfunction
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
    import sbs_pkg::*;
(
    input  logic             start_a,
    input  logic             start_b,
    input  logic             adv,
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             gwr,
    input  logic             bwen,
    input  logic [BYTES-1:0] bsel,
    input  logic             sleep,
    input  logic             burst_on,
    output cmd_t             cmd
);
    logic             sel;
    logic             wr_req;
    logic [BYTES-1:0] wmask;

    assign sel    = !cs1_n && cs2 && !cs3_n;
    assign wr_req = gwr || (bwen && (|bsel));
    assign wmask  = gwr ? {BYTES{1'b1}} : (bwen ? bsel : {BYTES{1'b0}});

    always_comb begin
        cmd.kind = K_NONE;
        cmd.wr   = 1'b0;
        cmd.mask = wmask;
        if (!sleep) begin
            if (start_a && !cs1_n) begin
                cmd.kind = sel ? K_LOAD : K_DESEL;
            end else if (start_b) begin
                cmd.kind = sel ? K_LOAD : K_DESEL;
                cmd.wr   = sel && wr_req;
            end else if (burst_on) begin
                cmd.kind = adv ? K_STEP : K_HOLD;
                cmd.wr   = wr_req;
            end
        end
    end
endmodule

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          cmd,
    input  logic [AW-1:0] addr,
    input  logic          order_lin,
    output logic [AW-1:0] acc_addr,
    output logic          burst_on
);
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_n;
    logic          on_q;

    always_comb begin
        cnt_n = cnt_q;
        unique case (cmd.kind)
            K_LOAD:  cnt_n = 2'd0;
            K_STEP:  cnt_n = cnt_q + 2'd1;
            default: cnt_n = cnt_q;
        endcase
    end

    always_comb begin
        if (cmd.kind == K_LOAD) begin
            acc_addr = addr;
        end else begin
            acc_addr = {base_q[AW-1:2], burst_lo(base_q[1:0], cnt_n, order_lin)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
            on_q   <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            if (cmd.kind == K_LOAD) begin
                base_q <= addr;
                on_q   <= 1'b1;
            end else if (cmd.kind == K_DESEL) begin
                on_q   <= 1'b0;
            end
        end
    end

    assign burst_on = on_q;
endmodule

// File: rtl/sbs_byte_array.sv
module sbs_byte_array
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BYTES-1:0]  mask,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && mask[b]) begin
                lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/sbs_read_port.sv
module sbs_read_port
    import sbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_sel,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic              rd_acc,
    input  logic              desel,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    logic              rd_q;
    logic              prd_q;
    logic              desel_q;
    logic [WORD_W-1:0] pdata_q;
    logic              drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= 1'b0;
            prd_q   <= 1'b0;
            desel_q <= 1'b0;
            pdata_q <= '0;
        end else begin
            rd_q    <= rd_acc;
            desel_q <= desel;
            prd_q   <= rd_q && !sleep;
            if (rd_q) begin
                pdata_q <= arr_rdata;
            end
        end
    end

    always_comb begin
        if (pipe_sel) begin
            drive = prd_q && !desel_q;
        end else begin
            drive = rd_q;
        end
        drive  = drive && !oe_n && !sleep;
        rvalid = drive;
        rdata  = drive ? (pipe_sel ? pdata_q : arr_rdata) : '0;
    end
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              start_a,
    input  logic              start_b,
    input  logic              adv,
    input  logic              gwr,
    input  logic              bwen,
    input  logic [BYTES-1:0]  bsel,
    input  logic              pipe_sel,
    input  logic              order_lin,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    cmd_t              cmd;
    logic              burst_on;
    logic [AW-1:0]     acc_addr;
    logic [AW-1:0]     raddr_q;
    logic              wr_en;
    logic              rd_acc;
    logic [WORD_W-1:0] arr_rdata;

    sbs_cmd_decode u_dec (
        .start_a  (start_a),
        .start_b  (start_b),
        .adv      (adv),
        .cs1_n    (cs1_n),
        .cs2      (cs2),
        .cs3_n    (cs3_n),
        .gwr      (gwr),
        .bwen     (bwen),
        .bsel     (bsel),
        .sleep    (sleep),
        .burst_on (burst_on),
        .cmd      (cmd)
    );

    sbs_burst_gen #(.AW(AW)) u_burst (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .addr      (addr),
        .order_lin (order_lin),
        .acc_addr  (acc_addr),
        .burst_on  (burst_on)
    );

    assign wr_en  = is_access(cmd.kind) && cmd.wr;
    assign rd_acc = is_access(cmd.kind) && !cmd.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            raddr_q <= '0;
        end else if (rd_acc) begin
            raddr_q <= acc_addr;
        end
    end

    sbs_byte_array #(.AW(AW)) u_array (
        .clk   (clk),
        .we    (wr_en),
        .mask  (cmd.mask),
        .waddr (acc_addr),
        .wdata (wdata),
        .raddr (raddr_q),
        .rdata (arr_rdata)
    );

    sbs_read_port u_rport (
        .clk       (clk),
        .rst       (rst),
        .pipe_sel  (pipe_sel),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .rd_acc    (rd_acc),
        .desel     (cmd.kind == K_DESEL),
        .arr_rdata (arr_rdata),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
    import sbs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              start_a,
    input logic              start_b,
    input logic              gwr,
    input logic              pipe_sel,
    input logic              oe_n,
    input logic              sleep,
    input logic [WORD_W-1:0] rdata,
    input logic              rvalid
);
    logic sel_w;
    logic a_live;
    logic desel_w;

    assign sel_w   = !cs1_n && cs2 && !cs3_n;
    assign a_live  = start_a && !cs1_n;
    assign desel_w = !sel_w && (a_live || start_b);

    p_flow_drive_r2: assert property (@(posedge clk) disable iff (rst)
        (a_live && sel_w && !sleep && !pipe_sel)
        |=> (oe_n || sleep || pipe_sel || rvalid));

    p_pipe_drive_r3: assert property (@(posedge clk) disable iff (rst)
        (a_live && sel_w && !sleep && pipe_sel) ##1 (pipe_sel && !sleep && !desel_w)
        |=> (oe_n || sleep || !pipe_sel || rvalid));

    p_desel_off_r9: assert property (@(posedge clk) disable iff (rst)
        (desel_w && !sleep) |=> !rvalid);

    p_write_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (start_b && !a_live && sel_w && gwr && !sleep && !pipe_sel)
        |=> (pipe_sel || !rvalid));

    p_oe_off_r10: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!rvalid && rdata == '0));

    p_sleep_off_r11: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (!rvalid && rdata == '0));
endmodule

bind sburst_sram sbs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs1_n    (cs1_n),
    .cs2      (cs2),
    .cs3_n    (cs3_n),
    .start_a  (start_a),
    .start_b  (start_b),
    .gwr      (gwr),
    .pipe_sel (pipe_sel),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .rdata    (rdata),
    .rvalid   (rvalid)
);

// File: tb/tb_sburst_sram.sv
module tb_sburst_sram;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst;
    logic [AW-1:0] addr;
    logic [35:0] wdata;
    logic        cs1_n, cs2, cs3_n;
    logic        start_a, start_b, adv, gwr, bwen;
    logic [3:0]  bsel;
    logic        pipe_sel, order_lin, oe_n, sleep;
    logic [35:0] rdata;
    logic        rvalid;

    int n_chk = 0;
    int n_bad = 0;
    logic [35:0] shadow [DEPTH];

    always #10 clk = ~clk;

    sburst_sram #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .start_a(start_a), .start_b(start_b), .adv(adv),
        .gwr(gwr), .bwen(bwen), .bsel(bsel),
        .pipe_sel(pipe_sel), .order_lin(order_lin),
        .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [35:0] pat(input int a);
        logic [63:0] v;
        v = 64'h9_3C5A_1E07 ^ (64'(a) * 64'h0_0402_0109);
        return v[35:0];
    endfunction

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        start_a = 0; start_b = 0; adv = 0; gwr = 0; bwen = 0; bsel = 4'h0;
        cs1_n = 0; cs2 = 1; cs3_n = 0; oe_n = 0; sleep = 0; wdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic deselect();
        idle(); start_b = 1; cs2 = 0; tick(); idle();
    endtask

    task automatic wr(input int a, input logic [35:0] d, input logic g,
                      input logic bw, input logic [3:0] bs);
        idle(); start_b = 1; addr = AW'(a); wdata = d; gwr = g; bwen = bw; bsel = bs;
        tick();
        if (g) shadow[a] = d;
        else if (bw) for (int i = 0; i < 4; i++)
            if (bs[i]) shadow[a][i*9 +: 9] = d[i*9 +: 9];
        deselect();
    endtask

    task automatic rd_flow(input int a, input string tag);
        idle(); start_a = 1; addr = AW'(a); tick();
        chk({tag, " valid"}, 36'(rvalid), 36'd1);
        chk(tag, rdata, shadow[a]);
        deselect();
    endtask

    task automatic burst(input int b, input logic lin, input logic pp);
        logic [AW-1:0] e [5];
        for (int j = 0; j < 5; j++) begin
            logic [1:0] lo;
            lo = lin ? 2'(b + j) : (2'(b) ^ 2'(j));
            e[j] = {AW'(b) >> 2, lo};
        end
        deselect();
        pipe_sel = pp; order_lin = lin;
        for (int j = 0; j < 6; j++) begin
            idle();
            if (j == 0) begin start_b = 1; addr = AW'(b); end
            else if (j <= 4) adv = 1;
            tick();
            if (!pp && j <= 4) chk($sformatf("R4 burst flow lin=%0d j=%0d", lin, j), rdata, shadow[e[j]]);
            if (pp && j >= 1) chk($sformatf("R4 burst pipe lin=%0d j=%0d", lin, j), rdata, shadow[e[j-1]]);
        end
        deselect();
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(); addr = '0; pipe_sel = 1; order_lin = 0; rst = 1;
        tick(); tick();
        rst = 0;
        // R12: reset state, adv alone starts nothing
        chk("R12 rvalid after reset", 36'(rvalid), 36'd0);
        adv = 1; tick();
        chk("R12 adv without start", 36'(rvalid), 36'd0);
        pipe_sel = 0; tick();
        chk("R12 adv without start flow", 36'(rvalid), 36'd0);

        // R7 fill memory with global writes
        for (int a = 0; a < DEPTH; a++) wr(a, pat(a), 1'b1, 1'b0, 4'h0);

        // R2 flow-through sweep
        pipe_sel = 0;
        for (int a = 0; a < DEPTH; a++) rd_flow(a, "R2 flow read");

        // R3 pipeline back-to-back sweep
        pipe_sel = 1;
        for (int a = 0; a < DEPTH; a++) begin
            idle(); start_a = 1; addr = AW'(a); tick();
            if (a > 0) chk("R3 pipe stream", rdata, shadow[a-1]);
        end
        idle(); tick();
        chk("R3 pipe last", rdata, shadow[DEPTH-1]);
        deselect();

        // R4 bursts, all offsets, both orders and modes
        for (int b = 8; b < 12; b++)
            for (int m = 0; m < 4; m++) burst(b, m[0], m[1]);

        // R6 byte writes over all masks, R5 read when no byte selected
        pipe_sel = 0;
        for (int m = 0; m < 16; m++) begin
            wr(16 + m, ~pat(16 + m), 1'b0, 1'b1, 4'(m));
            rd_flow(16 + m, "R6 byte write");
            wr(32 + m, 36'h0, 1'b0, 1'b0, 4'(m));
            rd_flow(32 + m, "R5 bwen low no write");
        end

        // R7 global write overrides byte controls
        for (int i = 0; i < 4; i++) begin
            wr(48 + i, 36'hF_0F0F_0F0F ^ 36'(i), 1'b1, i[0], 4'h1 << i);
            rd_flow(48 + i, "R7 global override");
        end

        // R8 start_a ignores write controls, priority over start_b
        idle(); start_a = 1; start_b = 1; gwr = 1; addr = 6'd5; wdata = '0; tick();
        chk("R8 start_a reads", rdata, shadow[5]);
        deselect();
        rd_flow(5, "R8 start_a no write");
        // R8 start_a ignored with cs1_n high: burst holds
        idle(); start_b = 1; addr = 6'd7; tick();
        idle(); start_a = 1; cs1_n = 1; addr = 6'd9; tick();
        chk("R8 ignored start_a valid", 36'(rvalid), 36'd1);
        chk("R8 ignored start_a held addr", rdata, shadow[7]);
        deselect();

        // R1/R9 deselect in flow mode, each select pin
        for (int k = 0; k < 3; k++) begin
            idle(); start_b = 1; addr = 6'd3; tick();
            chk("R1 selected read", rdata, shadow[3]);
            idle(); start_b = 1; cs1_n = (k == 0); cs2 = (k != 1); cs3_n = (k == 2); tick();
            chk("R1 deselect off", 36'(rvalid), 36'd0);
            idle(); adv = 1; tick();
            chk("R9 adv after deselect", 36'(rvalid), 36'd0);
        end
        // R5 write quiet in flow
        idle(); start_b = 1; gwr = 1; addr = 6'd60; wdata = pat(60); tick();
        chk("R5 write no drive", 36'(rvalid), 36'd0);
        deselect();

        // R9 pipeline: deselect right after read cuts the word
        pipe_sel = 1;
        idle(); start_a = 1; addr = 6'd3; tick();
        idle(); start_b = 1; cs2 = 0; tick();
        chk("R9 pipe read cut by deselect", 36'(rvalid), 36'd0);
        idle(); start_a = 1; addr = 6'd4; tick();
        idle(); tick();
        chk("R9 pipe read kept without deselect", rdata, shadow[4]);
        deselect();

        // R10 async output enable
        pipe_sel = 0;
        idle(); start_a = 1; addr = 6'd4; tick();
        chk("R10 before oe", rdata, shadow[4]);
        oe_n = 1; #2;
        chk("R10 oe high rvalid", 36'(rvalid), 36'd0);
        chk("R10 oe high rdata", rdata, 36'd0);
        oe_n = 0; #2;
        chk("R10 oe restored", rdata, shadow[4]);
        deselect();

        // R11 sleep
        idle(); start_a = 1; addr = 6'd6; tick();
        start_a = 0; sleep = 1; #2;
        chk("R11 sleep output off", {35'd0, rvalid} | rdata, 36'd0);
        start_b = 1; gwr = 1; addr = 6'd6; wdata = 36'h0; tick(); tick();
        sleep = 0; start_b = 0; gwr = 0; start_a = 1; addr = 6'd6; tick();
        chk("R11 first edge after wake", rdata, shadow[6]);
        chk("R11 wake valid", 36'(rvalid), 36'd1);
        deselect();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule